// File: doc/BRIEF.md
# Paired-Channel Simultaneous Sample Sequencer

This block times one conversion of a two-group converter that samples a matched channel pair at the same instant. One 3-bit index selects channel k of group A and channel k of group B together, so a mismatched pair cannot be requested. A start request can come from any of three sources: a PWM event, a software write or an external start pin. After a request is taken, the block waits two and a half converter clocks. It then drives a sample/hold pulse whose width is set by a 4-bit acquisition value. Both channels' data are captured on the falling edge of that pulse. The block then writes the group A and group B result registers at fixed offsets, each with a one-cycle write strobe, and raises an interrupt flag shortly after the B write.

The converter clock is not a separate input. A tick generator divides the system clock into half-converter-clock ticks (`HALF_DIV` system clocks per tick), so half-cycle offsets are counted exactly. The divider restarts whenever a request is taken. With the repeat input held high, the pulse re-arms two converter clocks after each fall, so results stream out at a steady spacing. Requests that arrive while the block is busy are dropped and recorded in a sticky overflow flag.

Top module: `adc_simul_seq`

## Requirements
- R1: When the block is idle (no pulse sequence active and no result pending), a one-cycle high on `trig_pwm`, `trig_sw` or `trig_ext` is taken at that clock edge. At the same edge `mux_addr` loads `pair_sel` and keeps that value until the next request is taken; later changes on `pair_sel` do not affect it.
- R2: `sh_pulse` rises exactly 5 half-ticks (5*`HALF_DIV` system clocks) after the edge at which the request was taken.
- R3: `sh_pulse` stays high for 2*(1+A) half-ticks. A is the `acq_sel` value (0 to 15) latched when the request was taken.
- R4: The values on `din_a` and `din_b` at the clock edge where `sh_pulse` falls are the values that later appear in `res_a` and `res_b`.
- R5: `res_a` is updated 8 half-ticks after that falling edge, and `res_b` 10 half-ticks after it. Each update is marked by a one-cycle high on `a_wr` or `b_wr`, respectively, and the two strobes are never high together.
- R6: If `cont_en` is high at the edge 4 half-ticks after a fall, `sh_pulse` rises again at that edge with the same width. Successive results on each channel are therefore 2*(3+A) half-ticks apart. If `cont_en` is low at that edge, the sequence ends.
- R7: `int_flag` is set two system clocks after each `b_wr` update edge. It is cleared by a one-cycle high on `int_clr`, and a set in the same cycle takes priority over the clear.
- R8: A request while busy is ignored: it changes neither the pulse timing nor `mux_addr`. Such a request sets the sticky `ovf_flag`, which `ovf_clr` clears.
- R9: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pwm | input | 1 | Start request from PWM event |
| trig_sw | input | 1 | Start request from software write |
| trig_ext | input | 1 | Start request from external pin |
| pair_sel | input | 3 | Matched channel pair index |
| acq_sel | input | 4 | Acquisition width setting A |
| cont_en | input | 1 | Re-arm the pulse after each conversion |
| din_a | input | 12 | Group A conversion data |
| din_b | input | 12 | Group B conversion data |
| int_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| sh_pulse | output | 1 | Sample/hold pulse |
| mux_addr | output | 3 | Selected pair address |
| res_a | output | 12 | Group A result register |
| res_b | output | 12 | Group B result register |
| a_wr | output | 1 | Group A result write strobe |
| b_wr | output | 1 | Group B result write strobe |
| int_flag | output | 1 | Conversion-done interrupt flag |
| ovf_flag | output | 1 | Dropped-request flag |

## Verification
The hardest state to reach is repeat mode at the smallest acquisition value. There, a fresh pulse falls before the previous sample's results have been written, so two samples are in flight in the result path at once. The stimulus holds `cont_en` high across several conversions with A at 0 and then at 3. It changes the data inputs every cycle, so a capture taken at the wrong edge shows up as a wrong result. A behavioural model schedules every rise, fall and write by absolute cycle number and is compared against all outputs on every clock. Requests are also fired in the middle of a repeat run and during the draining phase to exercise the overflow path.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DLY  = 2'd1,
    SEQ_SH   = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_t;

  // half-ticks from request to pulse rise
  localparam int TRIG_DLY_HT = 5;
  // half-ticks from pulse fall to next rise in repeat mode
  localparam int GAP_HT      = 4;
  // half-ticks from pulse fall to the result writes
  localparam int LAT_A_HT    = 8;
  localparam int LAT_B_HT    = 10;

endpackage

// File: rtl/adc_halftick.sv
module adc_halftick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = (div_q == LAST);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> !tick);

endmodule

// File: rtl/adc_sh_seq.sv
module adc_sh_seq
  import adc_seq_pkg::*;
#(
  parameter int ACQW  = 4,
  parameter int PAIRW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             trig_any,
  input  logic             pipe_busy,
  input  logic             cont_en,
  input  logic [PAIRW-1:0] pair_sel,
  input  logic [ACQW-1:0]  acq_sel,
  output logic             accept,
  output logic             fall_now,
  output logic             sh_o,
  output logic [PAIRW-1:0] mux_addr
);
  localparam int CNTW = ACQW + 2;
  localparam logic [CNTW-1:0] DLY_LAST = CNTW'(TRIG_DLY_HT - 1);
  localparam logic [CNTW-1:0] GAP_LAST = CNTW'(GAP_HT - 1);

  seq_state_t      state_q;
  logic [CNTW-1:0] cnt_q;
  logic [ACQW-1:0] acq_q;
  logic [CNTW-1:0] sh_last;
  logic            dly_done;
  logic            gap_done;

  // pulse spans 2*(1+A) half-ticks; last count index is 2*A+1
  assign sh_last  = CNTW'({acq_q, 1'b1});
  assign accept   = trig_any && (state_q == SEQ_IDLE) && !pipe_busy;
  assign dly_done = tick && (state_q == SEQ_DLY) && (cnt_q == DLY_LAST);
  assign fall_now = tick && (state_q == SEQ_SH)  && (cnt_q == sh_last);
  assign gap_done = tick && (state_q == SEQ_GAP) && (cnt_q == GAP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      acq_q    <= '0;
      sh_o     <= 1'b0;
      mux_addr <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q  <= SEQ_DLY;
            cnt_q    <= '0;
            acq_q    <= acq_sel;
            mux_addr <= pair_sel;
          end
        end
        SEQ_DLY: begin
          if (dly_done) begin
            state_q <= SEQ_SH;
            cnt_q   <= '0;
            sh_o    <= 1'b1;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_SH: begin
          if (fall_now) begin
            state_q <= SEQ_GAP;
            cnt_q   <= '0;
            sh_o    <= 1'b0;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SEQ_GAP: begin
          if (gap_done) begin
            cnt_q <= '0;
            if (cont_en) begin
              state_q <= SEQ_SH;
              sh_o    <= 1'b1;
            end else begin
              state_q <= SEQ_IDLE;
            end
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R2
  sh_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sh_o) |-> $past(tick));

  // R3
  acq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_o && $past(sh_o)) |-> $stable(acq_q));

  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != SEQ_IDLE && $past(state_q) != SEQ_IDLE) |-> $stable(mux_addr));

endmodule

// File: rtl/adc_result_pipe.sv
module adc_result_pipe
  import adc_seq_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          push,
  input  logic [DW-1:0] din_a,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] res_a,
  output logic [DW-1:0] res_b,
  output logic          a_wr,
  output logic          b_wr,
  output logic          busy
);
  localparam int DEPTH = LAT_B_HT;
  localparam int TAP_A = LAT_A_HT - 1;
  localparam int TAP_B = LAT_B_HT - 1;

  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    da_q [DEPTH];
  logic [DW-1:0]    db_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= 1'b0;
    end else if (tick) begin
      vld_q[0] <= push;
    end
  end

  always_ff @(posedge clk) begin
    if (tick) begin
      da_q[0] <= din_a;
      db_q[0] <= din_b;
    end
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
      end else if (tick) begin
        vld_q[g] <= vld_q[g-1];
      end
    end
    always_ff @(posedge clk) begin
      if (tick) begin
        da_q[g] <= da_q[g-1];
        db_q[g] <= db_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_a <= '0;
      res_b <= '0;
      a_wr  <= 1'b0;
      b_wr  <= 1'b0;
    end else begin
      a_wr <= tick && vld_q[TAP_A];
      b_wr <= tick && vld_q[TAP_B];
      if (tick && vld_q[TAP_A]) res_a <= da_q[TAP_A];
      if (tick && vld_q[TAP_B]) res_b <= db_q[TAP_B];
    end
  end

  assign busy = |vld_q;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(a_wr && b_wr));

  // R5
  a_wr_tick_chk: assert property (@(posedge clk) disable iff (rst)
    a_wr |-> $past(tick));

  // R5
  a_wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    a_wr |=> !a_wr);

  // R4
  push_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (push && tick) |=> vld_q[0]);

endmodule

// File: rtl/adc_simul_seq.sv
module adc_simul_seq
  import adc_seq_pkg::*;
#(
  parameter int DW       = 12,
  parameter int ACQW     = 4,
  parameter int PAIRW    = 3,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_pwm,
  input  logic             trig_sw,
  input  logic             trig_ext,
  input  logic [PAIRW-1:0] pair_sel,
  input  logic [ACQW-1:0]  acq_sel,
  input  logic             cont_en,
  input  logic [DW-1:0]    din_a,
  input  logic [DW-1:0]    din_b,
  input  logic             int_clr,
  input  logic             ovf_clr,
  output logic             sh_pulse,
  output logic [PAIRW-1:0] mux_addr,
  output logic [DW-1:0]    res_a,
  output logic [DW-1:0]    res_b,
  output logic             a_wr,
  output logic             b_wr,
  output logic             int_flag,
  output logic             ovf_flag
);
  logic trig_any;
  logic tick;
  logic accept;
  logic fall_now;
  logic pipe_busy;
  logic b_wr_d;

  assign trig_any = trig_pwm | trig_sw | trig_ext;

  adc_halftick #(
    .HALF_DIV (HALF_DIV)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .tick    (tick)
  );

  adc_sh_seq #(
    .ACQW  (ACQW),
    .PAIRW (PAIRW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .trig_any  (trig_any),
    .pipe_busy (pipe_busy),
    .cont_en   (cont_en),
    .pair_sel  (pair_sel),
    .acq_sel   (acq_sel),
    .accept    (accept),
    .fall_now  (fall_now),
    .sh_o      (sh_pulse),
    .mux_addr  (mux_addr)
  );

  adc_result_pipe #(
    .DW (DW)
  ) u_pipe (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .push  (fall_now),
    .din_a (din_a),
    .din_b (din_b),
    .res_a (res_a),
    .res_b (res_b),
    .a_wr  (a_wr),
    .b_wr  (b_wr),
    .busy  (pipe_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      b_wr_d   <= 1'b0;
      int_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      b_wr_d <= b_wr;
      if (b_wr_d)       int_flag <= 1'b1;
      else if (int_clr) int_flag <= 1'b0;
      if (trig_any && !accept) ovf_flag <= 1'b1;
      else if (ovf_clr)        ovf_flag <= 1'b0;
    end
  end

  // R7
  int_after_b_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(int_flag) |-> $past(b_wr, 2));

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(trig_any));

  // R8
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_pulse && trig_any) |=> $stable(mux_addr));

endmodule

// File: tb/tb_adc_simul_seq.sv
`timescale 1ns/1ps
module tb_adc_simul_seq;
  localparam int DW = 12;
  localparam int D  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_pwm = 0, trig_sw = 0, trig_ext = 0;
  logic [2:0] pair_sel = '0;
  logic [3:0] acq_sel = '0;
  logic cont_en = 0, int_clr = 0, ovf_clr = 0;
  logic [DW-1:0] din_a = '0, din_b = '0;
  logic sh_pulse, a_wr, b_wr, int_flag, ovf_flag;
  logic [2:0] mux_addr;
  logic [DW-1:0] res_a, res_b;

  always #2.5 clk = ~clk;

  adc_simul_seq #(.DW(DW), .HALF_DIV(D)) dut (
    .clk(clk), .rst(rst), .trig_pwm(trig_pwm), .trig_sw(trig_sw), .trig_ext(trig_ext),
    .pair_sel(pair_sel), .acq_sel(acq_sel), .cont_en(cont_en),
    .din_a(din_a), .din_b(din_b), .int_clr(int_clr), .ovf_clr(ovf_clr),
    .sh_pulse(sh_pulse), .mux_addr(mux_addr), .res_a(res_a), .res_b(res_b),
    .a_wr(a_wr), .b_wr(b_wr), .int_flag(int_flag), .ovf_flag(ovf_flag));

  int total = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // changing data every cycle so the capture edge is visible
  always @(negedge clk) begin
    din_a <= din_a + 12'd37;
    din_b <= din_b + 12'd91;
  end

  // behavioural reference: events scheduled by absolute edge number
  int n = 0;
  bit ev_rise [int];
  bit ev_fall [int];
  bit ev_gap  [int];
  bit ev_int  [int];
  logic [DW-1:0] ev_a [int];
  logic [DW-1:0] ev_b [int];
  bit m_sh, m_awr, m_bwr, m_int, m_ovf, m_seq;
  logic [DW-1:0] m_ra, m_rb;
  int m_pair, m_acq, last_b;

  always @(posedge clk) begin
    n++;
    if (rst) begin
      ev_rise.delete(); ev_fall.delete(); ev_gap.delete(); ev_int.delete();
      ev_a.delete(); ev_b.delete();
      m_sh = 0; m_awr = 0; m_bwr = 0; m_int = 0; m_ovf = 0; m_seq = 0;
      m_ra = '0; m_rb = '0; m_pair = 0; m_acq = 0; last_b = -1;
    end else begin
      bit busy;
      bit trig;
      busy = m_seq || (last_b >= n);
      trig = trig_pwm | trig_sw | trig_ext;
      if (ev_fall.exists(n)) begin
        m_sh = 0;
        ev_a[n + 8*D] = din_a;
        ev_b[n + 10*D] = din_b;
        last_b = n + 10*D;
        ev_int[n + 10*D + 2] = 1;
        ev_gap[n + 4*D] = 1;
      end
      if (ev_rise.exists(n)) begin
        m_sh = 1;
        ev_fall[n + 2*(1+m_acq)*D] = 1;
      end
      if (ev_gap.exists(n)) begin
        if (cont_en) begin
          m_sh = 1;
          ev_fall[n + 2*(1+m_acq)*D] = 1;
        end else m_seq = 0;
      end
      m_awr = ev_a.exists(n);
      if (m_awr) m_ra = ev_a[n];
      m_bwr = ev_b.exists(n);
      if (m_bwr) m_rb = ev_b[n];
      if (ev_int.exists(n)) m_int = 1;
      else if (int_clr) m_int = 0;
      if (trig && busy) m_ovf = 1;
      else begin
        if (ovf_clr) m_ovf = 0;
        if (trig) begin
          m_seq = 1;
          m_pair = int'(pair_sel);
          m_acq = int'(acq_sel);
          ev_rise[n + 5*D] = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && n > 0) begin
      chk("R2 R3 R6", "sh_pulse", 32'(sh_pulse), 32'(m_sh));
      chk("R1", "mux_addr", 32'(mux_addr), 32'(m_pair));
      chk("R4 R5", "res_a", 32'(res_a), 32'(m_ra));
      chk("R4 R5", "res_b", 32'(res_b), 32'(m_rb));
      chk("R5", "a_wr", 32'(a_wr), 32'(m_awr));
      chk("R5", "b_wr", 32'(b_wr), 32'(m_bwr));
      chk("R7", "int_flag", 32'(int_flag), 32'(m_int));
      chk("R8", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
    end
  end

  task automatic fire(int src, int pair, int acq);
    @(negedge clk);
    pair_sel = 3'(pair);
    acq_sel  = 4'(acq);
    if (src == 0) trig_pwm = 1;
    else if (src == 1) trig_sw = 1;
    else trig_ext = 1;
    @(negedge clk);
    trig_pwm = 0; trig_sw = 0; trig_ext = 0;
  endtask

  task automatic pulse_clr(bit do_int, bit do_ovf);
    @(negedge clk);
    int_clr = do_int; ovf_clr = do_ovf;
    @(negedge clk);
    int_clr = 0; ovf_clr = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R9: reset state
    chk("R9", "reset sh", 32'(sh_pulse), 0);
    chk("R9", "reset res", 32'({res_a, res_b}), 0);
    chk("R9", "reset flags", 32'({a_wr, b_wr, int_flag, ovf_flag, mux_addr}), 0);

    // R1 R2 R3: single shot, A=0, pair index changed mid-flight
    fire(0, 3, 0);
    repeat (3) @(negedge clk);
    pair_sel = 3'd5;
    repeat (60) @(negedge clk);
    pulse_clr(1, 0);

    // R3 R8: widest pulse, second request while busy
    fire(1, 7, 15);
    repeat (20) @(negedge clk);
    fire(2, 1, 2);
    repeat (150) @(negedge clk);
    pulse_clr(1, 1);

    // R5 R7: mid width from the external pin
    fire(2, 2, 5);
    repeat (100) @(negedge clk);
    pulse_clr(0, 1);

    // R6: repeat mode at smallest width, request during run
    cont_en = 1;
    fire(0, 1, 0);
    repeat (40) @(negedge clk);
    fire(1, 4, 9);
    repeat (20) @(negedge clk);
    pulse_clr(1, 0);
    cont_en = 0;
    repeat (80) @(negedge clk);
    pulse_clr(1, 1);

    // R6: repeat mode, A=3, clear overlapping int activity
    cont_en = 1;
    fire(1, 6, 3);
    repeat (100) @(negedge clk);
    cont_en = 0;
    repeat (25) @(negedge clk);
    fire(0, 0, 1);
    repeat (120) @(negedge clk);

    // R1 R2: back to idle, fresh request accepted again
    fire(0, 2, 1);
    repeat (80) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule